// File: doc/BRIEF.md
# Motor Command Frame Serialiser

This block turns one throttle command for a single motor into a 16-bit command word and sends it on one output line. The word holds an 11-bit throttle value, a request flag that asks the motor controller to send back telemetry, and a 4-bit XOR check code. The block sends the word most significant bit first. It stretches each bit into three equal sub-slots, so every bit starts with a high slot and ends with a low slot. The level of the middle slot carries the bit value. A 2-bit rate select chooses one of four bit rates. The block derives the slot length in clock cycles from the `CLK_HZ` parameter.

A single `send_i` strobe starts a frame. The block captures the command, the rate select and the mode flag at that edge. The frame then runs on its own. Strobes that arrive while a frame is running have no effect. When the last slot ends, `done_o` pulses for one cycle.

In bidirectional mode the block computes the check code over the bitwise inverse of the 12-bit payload and inverts the line polarity. The line therefore rests high between frames, which matches a pulled-up line that the motor controller may later drive in reply.

Top module: `mtr_frame_tx`

## Requirements
- R1: The transmitted word holds throttle_i in bits 15..5, telem_req_i in bit 4 and the check code in bits 3..0. The block sends bit 15 first and bit 0 last.
- R2: In plain mode (bidir_i = 0), the check code is the XOR of payload[3:0], payload[7:4] and payload[11:8], where payload = {throttle_i, telem_req_i}.
- R3: In bidirectional mode (bidir_i = 1), the block computes the check code the same way over ~payload. Bits 15..4 still carry the payload uninverted.
- R4: Each bit occupies three consecutive slots. Before polarity is applied, a 1 is sent as high, high, low and a 0 as high, low, low, which gives 48 slots per frame.
- R5: The slot length in cycles is 2 × floor(floor(CLK_HZ / (3 × rate)) / 2). rate_sel_i = 0, 1, 2, 3 selects 150, 300, 600 and 1200 kbit/s.
- R6: In bidirectional mode every slot level and the idle level are inverted, so after a bidirectional frame the line rests high. After a plain frame it rests low.
- R7: The frame has no start bit. The first slot begins in the cycle right after the clock edge that accepts send_i. After the 48th slot the line returns to its idle level: low before inversion.
- R8: A send_i pulse while busy_o is high is ignored. It does not change the frame in flight, and no second frame follows.
- R9: done_o is high for exactly one cycle, the cycle right after the last slot. busy_o falls at the same edge.
- R10: After reset, line_o, busy_o and done_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| throttle_i | input | 11 | Throttle value placed in word bits 15..5 |
| telem_req_i | input | 1 | Telemetry request flag, word bit 4 |
| bidir_i | input | 1 | Bidirectional mode: inverted-payload check code and inverted line |
| rate_sel_i | input | 2 | Bit rate select, 0..3 = 150/300/600/1200 kbit/s |
| send_i | input | 1 | Start strobe, accepted only while idle |
| line_o | output | 1 | Serial output line |
| busy_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | One-cycle pulse after the last slot |

## Verification
- A wrong slot counter or rate table changes the cycle at which a sub-slot edge moves. Every line is compared each cycle, so the error shows within the first slot.
- A bad word, a wrong check code or a wrong bit order first shows in the middle sub-slot of the affected bit. The check code is in the last four bits, so a check-code fault shows only near the end of the frame.
- A polarity fault is visible in the very first cycle of the frame and again on the idle level after it.
- A faulty end-of-frame decision shows one slot late or early on busy_o and done_o. A broken busy guard shows as a second frame after done_o.

// File: rtl/mtr_frame_pkg.sv
package mtr_frame_pkg;

    localparam int THR_W         = 11;
    localparam int PAY_W         = THR_W + 1;
    localparam int CSUM_W        = 4;
    localparam int WORD_W        = PAY_W + CSUM_W;
    localparam int SLOTS_PER_BIT = 3;
    localparam int FRAME_SLOTS   = WORD_W * SLOTS_PER_BIT;
    localparam int RATE_SEL_W    = 2;
    localparam int RATE_COUNT    = 1 << RATE_SEL_W;
    localparam int BIT_IDX_W     = $clog2(WORD_W);
    localparam int PHASE_W       = 2;
    localparam int unsigned BASE_RATE = 150_000;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic [THR_W-1:0] throttle;
        logic             telem;
    } payload_t;

    typedef struct packed {
        payload_t          pay;
        logic [CSUM_W-1:0] csum;
    } frame_word_t;

    typedef struct packed {
        frame_word_t           word;
        logic                  inv;
        logic [RATE_SEL_W-1:0] rate;
    } frame_req_t;

    // XOR-fold the payload nibble by nibble
    function automatic logic [CSUM_W-1:0] nib_fold(input logic [PAY_W-1:0] p);
        logic [CSUM_W-1:0] acc;
        acc = '0;
        for (int n = 0; n < PAY_W / CSUM_W; n++) begin
            acc = acc ^ p[n*CSUM_W +: CSUM_W];
        end
        return acc;
    endfunction

    // Slot length in clock cycles for a given rate select
    function automatic int unsigned slot_cycles(input int unsigned clk_hz, input int unsigned sel);
        int unsigned half;
        half = (clk_hz / (BASE_RATE * SLOTS_PER_BIT * (32'd1 << sel))) / 2;
        if (half < 1) half = 1;
        return half * 2;
    endfunction

endpackage

// File: rtl/mtr_word_build.sv
module mtr_word_build
    import mtr_frame_pkg::*;
(
    input  logic [THR_W-1:0] throttle,
    input  logic             telem,
    input  logic             bidir,
    output frame_word_t      word
);
    payload_t          pay;
    logic [PAY_W-1:0]  csum_src;

    always_comb begin
        pay.throttle = throttle;
        pay.telem    = telem;
        csum_src     = bidir ? ~pay : pay;
        word.pay     = pay;
        word.csum    = nib_fold(csum_src);
    end
endmodule

// File: rtl/mtr_slot_timer.sv
module mtr_slot_timer
    import mtr_frame_pkg::*;
#(
    parameter int unsigned CLK_HZ = 120_000_000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  run,
    input  logic [RATE_SEL_W-1:0] rate,
    output logic [BIT_IDX_W-1:0]  bit_idx,
    output logic [PHASE_W-1:0]    phase,
    output logic                  frame_end
);
    localparam int unsigned MAX_LEN = slot_cycles(CLK_HZ, 0);
    localparam int          CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] len_tbl [RATE_COUNT];
    logic [CNT_W-1:0] cnt;
    logic             slot_end;
    logic             last_bit;
    logic             last_phase;

    for (genvar g = 0; g < RATE_COUNT; g++) begin : g_rate
        assign len_tbl[g] = CNT_W'(slot_cycles(CLK_HZ, g));
    end

    assign slot_end   = run && (cnt == len_tbl[rate] - CNT_W'(1));
    assign last_bit   = bit_idx == BIT_IDX_W'(WORD_W - 1);
    assign last_phase = phase == PHASE_W'(SLOTS_PER_BIT - 1);
    assign frame_end  = slot_end && last_bit && last_phase;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt     <= '0;
            bit_idx <= '0;
            phase   <= '0;
        end else if (run) begin
            if (slot_end) begin
                cnt <= '0;
                if (last_phase) begin
                    phase <= '0;
                    if (!last_bit) bit_idx <= bit_idx + BIT_IDX_W'(1);
                end else begin
                    phase <= phase + PHASE_W'(1);
                end
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/mtr_bit_expander.sv
module mtr_bit_expander
    import mtr_frame_pkg::*;
(
    input  logic [WORD_W-1:0]    word,
    input  logic [BIT_IDX_W-1:0] bit_idx,
    input  logic [PHASE_W-1:0]   phase,
    input  logic                 active,
    input  logic                 inv,
    output logic                 line
);
    logic cur_bit;
    logic raw;

    always_comb begin
        cur_bit = word[BIT_IDX_W'(WORD_W - 1) - bit_idx];
        raw     = 1'b0;
        if (active) begin
            case (phase)
                2'd0:    raw = 1'b1;
                2'd1:    raw = cur_bit;
                default: raw = 1'b0;
            endcase
        end
        line = raw ^ inv;
    end
endmodule

// File: rtl/mtr_frame_tx.sv
module mtr_frame_tx
    import mtr_frame_pkg::*;
#(
    parameter int unsigned CLK_HZ = 120_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [10:0] throttle_i,
    input  logic        telem_req_i,
    input  logic        bidir_i,
    input  logic [1:0]  rate_sel_i,
    input  logic        send_i,
    output logic        line_o,
    output logic        busy_o,
    output logic        done_o
);
    tx_state_e            state;
    frame_req_t           req_q;
    frame_word_t          new_word;
    logic                 accept;
    logic                 frame_end;
    logic                 done_q;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic [PHASE_W-1:0]   slot_phase;
    logic [WORD_W-1:0]    word_bits;
    logic                 tx_inv;

    assign accept    = (state == TX_IDLE) && send_i;
    assign busy_o    = (state == TX_SEND);
    assign done_o    = done_q;
    assign word_bits = req_q.word;
    assign tx_inv    = req_q.inv;

    mtr_word_build u_build (
        .throttle (throttle_i),
        .telem    (telem_req_i),
        .bidir    (bidir_i),
        .word     (new_word)
    );

    mtr_slot_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .run       (busy_o),
        .rate      (req_q.rate),
        .bit_idx   (bit_idx),
        .phase     (slot_phase),
        .frame_end (frame_end)
    );

    mtr_bit_expander u_expand (
        .word    (word_bits),
        .bit_idx (bit_idx),
        .phase   (slot_phase),
        .active  (busy_o),
        .inv     (tx_inv),
        .line    (line_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            req_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state      <= TX_SEND;
                req_q.word <= new_word;
                req_q.inv  <= bidir_i;
                req_q.rate <= rate_sel_i;
            end else if (frame_end) begin
                state  <= TX_IDLE;
                done_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mtr_frame_tx_chk.sv
module mtr_frame_tx_chk (
    input logic        clk,
    input logic        rst,
    input logic        send_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        line_o,
    input logic        tx_inv,
    input logic [1:0]  slot_phase,
    input logic [15:0] word_bits
);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_busy_end_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    assert_ignore_send_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && send_i) |=> $stable(word_bits));

    assert_lead_slot_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && slot_phase == 2'd0) |-> (line_o == !tx_inv));

    assert_tail_slot_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && slot_phase == 2'd2) |-> (line_o == tx_inv));

    assert_idle_level_R6: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (line_o == tx_inv));

    assert_phase_range_R4: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (slot_phase <= 2'd2));
endmodule

bind mtr_frame_tx mtr_frame_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .send_i     (send_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .line_o     (line_o),
    .tx_inv     (tx_inv),
    .slot_phase (slot_phase),
    .word_bits  (word_bits)
);

// File: tb/tb_mtr_frame_tx.sv
`timescale 1ns/1ps
module tb_mtr_frame_tx;
    localparam int unsigned CLK_HZ = 120_000_000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] throttle_i = '0;
    logic        telem_req_i = 1'b0;
    logic        bidir_i = 1'b0;
    logic [1:0]  rate_sel_i = '0;
    logic        send_i = 1'b0;
    logic        line_o;
    logic        busy_o;
    logic        done_o;

    int vectors = 0;
    int misses  = 0;

    always #2 clk = ~clk;

    mtr_frame_tx #(.CLK_HZ(CLK_HZ)) dut (
        .clk(clk), .rst(rst), .throttle_i(throttle_i), .telem_req_i(telem_req_i),
        .bidir_i(bidir_i), .rate_sel_i(rate_sel_i), .send_i(send_i),
        .line_o(line_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int slot_len(input int sel);
        int half;
        half = (CLK_HZ / (3 * (150000 << sel))) / 2;
        return 2 * half;
    endfunction

    function automatic logic [15:0] ref_word(input logic [10:0] thr, input logic tel, input logic bid);
        logic [11:0] p;
        logic [11:0] q;
        p = {thr, tel};
        q = bid ? ~p : p;
        return {p, q[3:0] ^ q[7:4] ^ q[11:8]};
    endfunction

    task automatic check_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(line_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0, "R10 reset outputs",
            {line_o, busy_o, done_o}, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Send one frame and compare every cycle of it (R1..R7, R9), optional mid-frame strobe (R8)
    task automatic run_frame(input logic [10:0] thr, input logic tel, input logic bid,
                             input int sel, input bit poke, input string tag);
        logic [15:0] w;
        int s;
        int bad_c;
        int bad_act;
        int bad_exp;
        bit seen_busy_bad;
        w = ref_word(thr, tel, bid);
        s = slot_len(sel);
        bad_c = -1;
        bad_act = 0;
        bad_exp = 0;
        seen_busy_bad = 1'b0;
        throttle_i  = thr;
        telem_req_i = tel;
        bidir_i     = bid;
        rate_sel_i  = 2'(sel);
        send_i      = 1'b1;
        @(negedge clk);
        send_i = 1'b0;
        for (int c = 0; c < 48 * s; c++) begin
            int slot;
            int ph;
            logic lvl;
            slot = c / s;
            ph   = slot % 3;
            lvl  = (ph == 0) ? 1'b1 : (ph == 1) ? w[15 - slot / 3] : 1'b0;
            lvl  = lvl ^ bid;
            if (line_o !== lvl && bad_c < 0) begin
                bad_c = c;
                bad_act = line_o;
                bad_exp = lvl;
            end
            if (busy_o !== 1'b1 || done_o !== 1'b0) seen_busy_bad = 1'b1;
            if (poke && c == 10 * s) begin
                throttle_i = ~thr;
                bidir_i    = ~bid;
                send_i     = 1'b1;
            end
            @(negedge clk);
            send_i = 1'b0;
        end
        chk(bad_c < 0, {"R1 R4 R5 line pattern ", tag}, bad_act, bad_exp);
        if (bad_c >= 0) $display("  first mismatch at cycle %0d of frame, word %04h", bad_c, w);
        chk(!seen_busy_bad, {"R9 busy held during frame ", tag}, seen_busy_bad, 0);
        chk(done_o === 1'b1 && busy_o === 1'b0, {"R9 done after last slot ", tag},
            {done_o, busy_o}, 2'b10);
        chk(line_o === bid, {"R6 R7 idle level after frame ", tag}, line_o, bid);
        @(negedge clk);
        chk(done_o === 1'b0, {"R9 done single cycle ", tag}, done_o, 0);
        repeat (s) @(negedge clk);
        chk(busy_o === 1'b0 && line_o === bid, {"R8 no extra frame ", tag},
            {busy_o, line_o}, {1'b0, bid});
    endtask

    task automatic check_words();
        chk(ref_word(11'd0, 1'b0, 1'b1) == 16'h000F, "R3 known bidir word", ref_word(11'd0, 1'b0, 1'b1), 16'h000F);
        chk(ref_word(11'h400, 1'b1, 1'b0) == 16'h8019, "R2 known plain word", ref_word(11'h400, 1'b1, 1'b0), 16'h8019);
    endtask

    initial begin
        check_reset();
        check_words();
        run_frame(11'h7FF, 1'b1, 1'b0, 3, 1'b0, "R2 full-scale 1200k");
        run_frame(11'h400, 1'b0, 1'b0, 2, 1'b0, "R2 msb-only 600k");
        run_frame(11'h000, 1'b0, 1'b0, 3, 1'b0, "R2 zero 1200k");
        run_frame(11'h123, 1'b1, 1'b1, 1, 1'b0, "R3 R6 bidir 300k");
        run_frame(11'h2A5, 1'b0, 1'b1, 3, 1'b1, "R8 bidir poke 1200k");
        run_frame(11'h555, 1'b1, 1'b0, 0, 1'b0, "R5 plain 150k");
        run_frame(11'h0F0, 1'b0, 1'b0, 2, 1'b1, "R8 plain poke 600k");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #800000;
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule